// File: doc/BRIEF.md
# Sixteen-Operation Data-Processing ALU

This block is the arithmetic and logic stage of a 32-bit RISC integer datapath. It takes a 4-bit operation code from a data-processing instruction and two operands. Operand A is the first source register. Operand B is either the second source register or an immediate that has already been expanded. A carry-in comes from the flag register. It is purely combinational, so the result, the destination write-enable and the four condition flags settle in the same cycle as the inputs.

The sixteen operations fall into three groups:

- **Bitwise forms:** AND, exclusive-OR, inclusive-OR, bit-clear, move and move-not.
- **Arithmetic forms:** add, add-with-carry, subtract, reverse subtract, and the two carry-chained subtracts.
- **Test-only forms:** four operations that compute a bitwise or arithmetic result only to produce flags, and hold the register write off.

Shifting of operand B, storage of the flags and evaluation of conditions belong to neighbouring blocks.

The block has no state machine. Each operation is one named decode case, and decode completes in a single combinational pass with no states or transitions.

Top module: `dp_alu`

## Requirements
- R1: Bitwise forms give these results: op 0000 gives A&B, 0001 gives A^B, 1100 gives A|B and 1110 gives A&~B. The test forms 1000 and 1001 produce A&B and A^B on the result output.
- R2: Op 0010 (subtract) and op 1010 (compare) give A−B modulo 2^32. Op 0011 (reverse subtract) gives B−A.
- R3: Op 0100 (add) and op 1011 (compare-negative) give A+B. Op 0101 gives A+B+cin.
- R4: Op 0110 gives A−B−1+cin. Op 0111 gives B−A−1+cin.
- R5: Op 1101 returns B unchanged. Op 1111 returns ~B.
- R6: wr_en_o is 0 for ops 1000, 1001, 1010 and 1011, and 1 for every other op.
- R7: n_o equals bit 31 of the result. z_o is 1 exactly when the result is all zeros.
- R8: For the arithmetic ops (0010–0111, 1010, 1011), c_o is the unsigned carry-out of the addition, or NOT borrow for a subtraction. For all bitwise ops, c_o equals cin_i.
- R9: For the arithmetic ops, v_o is 1 exactly when the signed result overflows 32 bits. For the bitwise ops, v_o is 0.
- R10: A reverse subtract with operand B = 49 returns 49 − A. For A = 7 this is 42, with c_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A (first source register) |
| b_i | input | 32 | Operand B (second register or expanded immediate) |
| cin_i | input | 1 | Carry-in from the flag register |
| res_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination register write-enable |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| v_o | output | 1 | Overflow flag |

## Verification
Every output is due zero cycles after its stimulus, because no register lies between any input and any output. The driver applies each vector on a falling clock edge and records the expected values in the scoreboard queue. The monitor pops and compares them on the following rising edge, half a period later, after the combinational paths have settled. Every opcode is run against each pair of the corner operands 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, with both carry-in values, and then against random operands.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0,
        OP_EOR = 4'h1,
        OP_SUB = 4'h2,
        OP_RSB = 4'h3,
        OP_ADD = 4'h4,
        OP_ADC = 4'h5,
        OP_SBC = 4'h6,
        OP_RSC = 4'h7,
        OP_TST = 4'h8,
        OP_TEQ = 4'h9,
        OP_CMP = 4'hA,
        OP_CMN = 4'hB,
        OP_ORR = 4'hC,
        OP_MOV = 4'hD,
        OP_BIC = 4'hE,
        OP_MVN = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] x_o,
    output logic [W-1:0] y_o,
    output logic         c0_o,
    output logic         arith_o,
    output logic         wr_en_o
);

    alu_op_e op;
    assign op = alu_op_e'(op_i);

    always_comb begin
        x_o     = a_i;
        y_o     = b_i;
        c0_o    = 1'b0;
        arith_o = 1'b0;
        wr_en_o = 1'b1;
        unique case (op)
            OP_AND, OP_EOR, OP_ORR, OP_MOV, OP_BIC, OP_MVN: begin
                arith_o = 1'b0;
            end
            OP_TST, OP_TEQ: begin
                wr_en_o = 1'b0;
            end
            OP_SUB: begin
                y_o = ~b_i; c0_o = 1'b1; arith_o = 1'b1;
            end
            OP_CMP: begin
                y_o = ~b_i; c0_o = 1'b1; arith_o = 1'b1; wr_en_o = 1'b0;
            end
            OP_RSB: begin
                x_o = b_i; y_o = ~a_i; c0_o = 1'b1; arith_o = 1'b1;
            end
            OP_ADD: begin
                arith_o = 1'b1;
            end
            OP_CMN: begin
                arith_o = 1'b1; wr_en_o = 1'b0;
            end
            OP_ADC: begin
                c0_o = cin_i; arith_o = 1'b1;
            end
            OP_SBC: begin
                y_o = ~b_i; c0_o = cin_i; arith_o = 1'b1;
            end
            OP_RSC: begin
                x_o = b_i; y_o = ~a_i; c0_o = cin_i; arith_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dp_alu_adder.sv
module dp_alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         ci_i,
    output logic [W-1:0] sum_o,
    output logic         co_o,
    output logic         ov_o
);

    localparam int MSB = W - 1;

    logic [W:0] wide;

    assign wide  = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, ci_i};
    assign sum_o = wide[W-1:0];
    assign co_o  = wide[W];
    assign ov_o  = (x_i[MSB] == y_i[MSB]) && (wide[MSB] != x_i[MSB]);

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] out_o
);

    alu_op_e op;
    assign op = alu_op_e'(op_i);

    always_comb begin
        unique case (op)
            OP_AND, OP_TST: out_o = a_i & b_i;
            OP_EOR, OP_TEQ: out_o = a_i ^ b_i;
            OP_ORR:         out_o = a_i | b_i;
            OP_MOV:         out_o = b_i;
            OP_BIC:         out_o = a_i & ~b_i;
            OP_MVN:         out_o = ~b_i;
            default:        out_o = '0;
        endcase
    end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         wr_en_o,
    output logic         n_o,
    output logic         z_o,
    output logic         c_o,
    output logic         v_o
);

    logic [W-1:0] add_x, add_y, add_sum, log_out;
    logic         add_c0, add_co, add_ov, is_arith;
    alu_flags_t   flags;

    dp_alu_decode #(.W(W)) u_decode (
        .op_i    (op_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .cin_i   (cin_i),
        .x_o     (add_x),
        .y_o     (add_y),
        .c0_o    (add_c0),
        .arith_o (is_arith),
        .wr_en_o (wr_en_o)
    );

    dp_alu_adder #(.W(W)) u_adder (
        .x_i   (add_x),
        .y_i   (add_y),
        .ci_i  (add_c0),
        .sum_o (add_sum),
        .co_o  (add_co),
        .ov_o  (add_ov)
    );

    dp_alu_logic #(.W(W)) u_logic (
        .op_i  (op_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .out_o (log_out)
    );

    assign res_o = is_arith ? add_sum : log_out;

    always_comb begin
        flags.n = res_o[W-1];
        flags.z = ~|res_o;
        flags.c = is_arith ? add_co : cin_i;
        flags.v = is_arith ? add_ov : 1'b0;
    end

    assign n_o = flags.n;
    assign z_o = flags.z;
    assign c_o = flags.c;
    assign v_o = flags.v;

endmodule

// File: rtl/dp_alu_checks.sv
module dp_alu_checks #(
    parameter int W = 32
) (
    input logic [3:0]   op_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic         cin_i,
    input logic [W-1:0] res_o,
    input logic         wr_en_o,
    input logic         n_o,
    input logic         z_o,
    input logic         c_o,
    input logic         v_o
);

    logic known, test_form, bit_form;
    assign known     = !$isunknown({op_i, a_i, b_i, cin_i});
    assign test_form = (op_i[3:2] == 2'b10);
    assign bit_form  = (op_i == 4'h0) || (op_i == 4'h1) || (op_i == 4'h8) ||
                       (op_i == 4'h9) || (op_i >= 4'hC);

    always_comb begin
        if (known) begin
            assert_wr_en_R6: assert (wr_en_o == !test_form);
            assert_neg_R7: assert (n_o == res_o[W-1]);
            assert_zero_R7: assert (z_o == (res_o == '0));
            if (bit_form) begin
                assert_carry_pass_R8: assert (c_o == cin_i);
                assert_no_overflow_R9: assert (v_o == 1'b0);
            end
            if (op_i == 4'hD) begin
                assert_move_R5: assert (res_o == b_i);
            end
        end
    end

endmodule

bind dp_alu dp_alu_checks #(.W(W)) u_dp_alu_checks (
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin_i),
    .res_o   (res_o),
    .wr_en_o (wr_en_o),
    .n_o     (n_o),
    .z_o     (z_o),
    .c_o     (c_o),
    .v_o     (v_o)
);

// File: tb/dp_alu_bench.sv
`timescale 1ns/1ps
module dp_alu_bench;

    typedef struct {
        logic [3:0]  op;
        logic [31:0] a, b;
        logic        cin;
        logic [31:0] res;
        logic        wr, n, z, c, v;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic [3:0]  op;
    logic [31:0] a, b;
    logic        cin;
    logic [31:0] res;
    logic        wr, n, z, c, v;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    dp_alu u_dp_alu (
        .op_i(op), .a_i(a), .b_i(b), .cin_i(cin),
        .res_o(res), .wr_en_o(wr), .n_o(n), .z_o(z), .c_o(c), .v_o(v)
    );

    function automatic string op_tag(input logic [3:0] o);
        case (o)
            4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hE: return "R1";
            4'h2, 4'h3, 4'hA:                   return "R2";
            4'h4, 4'h5, 4'hB:                   return "R3";
            4'h6, 4'h7:                         return "R4";
            default:                            return "R5";
        endcase
    endfunction

    function automatic exp_t model(input logic [3:0] o, input logic [31:0] x,
                                   input logic [31:0] y, input logic ci);
        exp_t e;
        longint sx, sy, ux, uy, exact, uexact;
        bit arith;
        sx = longint'($signed(x)); sy = longint'($signed(y));
        ux = longint'({32'b0, x});  uy = longint'({32'b0, y});
        arith = 1'b1; exact = 0; uexact = 0;
        e.op = o; e.a = x; e.b = y; e.cin = ci; e.tag = op_tag(o);
        case (o)
            4'h2, 4'hA: begin exact = sx - sy; uexact = ux - uy; end
            4'h3:       begin exact = sy - sx; uexact = uy - ux; end
            4'h4, 4'hB: begin exact = sx + sy; uexact = ux + uy; end
            4'h5:       begin exact = sx + sy + ci; uexact = ux + uy + ci; end
            4'h6:       begin exact = sx - sy - 1 + ci; uexact = ux - uy - 1 + ci; end
            4'h7:       begin exact = sy - sx - 1 + ci; uexact = uy - ux - 1 + ci; end
            default:    arith = 1'b0;
        endcase
        if (arith) begin
            e.res = exact[31:0];
            e.v   = (exact > 64'sd2147483647) || (exact < -64'sd2147483648);
            case (o)
                4'h4, 4'h5, 4'hB: e.c = (uexact > 64'sd4294967295);
                default:          e.c = (uexact >= 0);
            endcase
        end else begin
            case (o)
                4'h0, 4'h8: e.res = x & y;
                4'h1, 4'h9: e.res = x ^ y;
                4'hC:       e.res = x | y;
                4'hD:       e.res = y;
                4'hE:       e.res = x & ~y;
                default:    e.res = ~y;
            endcase
            e.c = ci;
            e.v = 1'b0;
        end
        e.wr = !(o >= 4'h8 && o <= 4'hB);
        e.n  = e.res[31];
        e.z  = (e.res == 32'h0);
        return e;
    endfunction

    task automatic drive(input logic [3:0] o, input logic [31:0] x,
                         input logic [31:0] y, input logic ci);
        @(negedge clk);
        op = o; a = x; b = y; cin = ci;
        q.push_back(model(o, x, y, ci));
    endtask

    task automatic check1(input string req, input string what,
                          input logic [31:0] got, input logic [31:0] want,
                          input exp_t e);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s %s op=%h a=%h b=%h cin=%0d actual=%h expected=%h",
                     req, what, e.op, e.a, e.b, e.cin, got, want);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                check1(e.tag, "result", res, e.res, e);
                check1("R6", "wr_en", {31'b0, wr}, {31'b0, e.wr}, e);
                check1("R7", "N", {31'b0, n}, {31'b0, e.n}, e);
                check1("R7", "Z", {31'b0, z}, {31'b0, e.z}, e);
                check1("R8", "C", {31'b0, c}, {31'b0, e.c}, e);
                check1("R9", "V", {31'b0, v}, {31'b0, e.v}, e);
            end
        end
    end

    initial begin : watchdog
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1..: run did not complete, actual=hung expected=done");
            report();
        end
    end

    initial begin : stimulus
        logic [31:0] corner [5];
        exp_t e;
        corner[0] = 32'h0; corner[1] = 32'h1; corner[2] = 32'h7FFFFFFF;
        corner[3] = 32'h80000000; corner[4] = 32'hFFFFFFFF;
        op = 4'h0; a = '0; b = '0; cin = 1'b0;

        // R10: reverse subtract of an immediate 49 from A = 7
        drive(4'h3, 32'd7, 32'd49, 1'b0);
        @(posedge clk); #1;
        e = model(4'h3, 32'd7, 32'd49, 1'b0);
        check1("R10", "rsb49", res, 32'd42, e);
        check1("R10", "rsb49_c", {31'b0, c}, 32'd1, e);

        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    for (int k = 0; k < 2; k++)
                        drive(4'(o), corner[i], corner[j], 1'(k));

        for (int r = 0; r < 40; r++)
            for (int o = 0; o < 16; o++)
                drive(4'(o), $urandom, $urandom, 1'($urandom));

        // R10 again with a random-looking A
        drive(4'h3, 32'h00000100, 32'd49, 1'b1);
        @(posedge clk); #1;
        check1("R10", "rsb49_b", res, 32'd49 - 32'h100, e);

        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        report();
    end

endmodule